// File: doc/BRIEF.md
# I/O Page Register Responder

This block answers bus cycles aimed at an 8 KB I/O page. Each incoming offset is matched against a small table of register slots fixed by parameters at elaboration. A slot covers one or more consecutive 16-bit words starting at an even offset. Each slot carries its own options: whether it exists at all, whether it is a placeholder that reads zero, whether it rejects writes, whether its words cannot be read back, and whether a bus reset cycle clears it.

Four cycle kinds are served: word read, word write, byte write and bus reset. The bus has no byte read, so a byte read request is refused. A byte write is carried out on the addressed word as a read, a merge of one byte, and a word write, all in one cycle. If that internal read would fault, as on a write-only slot, zero stands in for the old word. Any access to an offset that no slot claims raises the error output and marks it as a bus timeout. The error output takes the place of the processor trap.

A requester raises `req` for one clock with the cycle kind, offset and write data. In the following cycle exactly one of `ack` or `err` is high, and read data is valid alongside `ack`.

Top module: `iopage_responder`

## Requirements
- R1: A request sampled at a rising edge produces exactly one of `ack` or `err` high in the following cycle, for one cycle. Idle cycles produce neither. `rdata` is zero whenever `ack` is low.
- R2: A word read (cyc=0) of a readable occupied word returns its stored 16-bit value. Bit 0 of the offset is ignored on word cycles, so an odd offset reaches the same word.
- R3: A word write (cyc=1) to a writable slot stores all 16 bits of `wdata`. The cycle is acked with `rdata` zero.
- R4: A byte write (cyc=2) takes the byte from `wdata[7:0]`. It replaces bits 15:8 of the word when offset bit 0 is 1, and bits 7:0 when it is 0. The other byte keeps its old value, and `wdata[15:8]` is ignored.
- R5: A write-only slot (flag bit 4) refuses word reads with `err` high and `err_tmo` low. A byte write to it is acked and merges into a zero old value.
- R6: A read or write to an offset claimed by no present slot (flag bit 0 clear, or outside every slot) raises `err` with `err_tmo` high and changes no stored word.
- R7: A dummy slot (flag bit 1) reads as zero. Writes of either size to it are acked and have no effect.
- R8: A word or byte write to a read-only slot (flag bit 2) raises `err` with `err_tmo` low and leaves the slot unchanged.
- R9: A bus reset cycle (cyc=3) is acked whatever the offset. It clears every word of slots with clear-on-reset (flag bit 3) and leaves all other words unchanged.
- R10: A slot spanning several words keeps one independent register per word, selected by the offset within the slot.
- R11: A byte read (cyc=4) and the undefined codes 5 to 7 raise `err` with `err_tmo` low and change nothing.
- R12: While `rst_n` is low, every word of each slot is loaded with that slot's initial value, and `ack`, `err`, `err_tmo` and `rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, one cycle per bus cycle |
| cyc | input | 3 | Cycle kind: 0 word read, 1 word write, 2 byte write, 3 bus reset, 4 byte read |
| addr | input | 13 | Byte offset within the I/O page |
| wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| ack | output | 1 | Cycle completed, one cycle after `req` |
| err | output | 1 | Address error, one cycle after `req` |
| err_tmo | output | 1 | Error is marked as a bus timeout (no device) |
| rdata | output | 16 | Read data, valid with `ack` |

## Verification
The bench builds the block with five slots and up to two words per slot. The slots are: a two-word clear-on-reset register with a non-zero initial value, a read-only register, a dummy, a write-only register that survives bus reset, and a slot whose present flag is clear. This set lets one run reach every option and every error path. It also reaches the word boundary just past a multi-word slot and the difference between a missing slot and an absent one. Because the initial values differ from one another, the bench can show that a bus reset clears only the flagged slot and that `rst_n` reloads each slot's own value.

// File: rtl/iop_pkg.sv
package iop_pkg;

    localparam int PAGE_AW = 13;
    localparam int DW      = 16;
    localparam int FLAG_W  = 5;
    localparam int WCNT_W  = 4;

    // slot option bit positions inside each FLAG_W-wide field
    localparam int FB_PRESENT = 0;
    localparam int FB_DUMMY   = 1;
    localparam int FB_RDONLY  = 2;
    localparam int FB_CLRRST  = 3;
    localparam int FB_WRONLY  = 4;

    typedef enum logic [2:0] {
        CYC_RD16 = 3'd0,
        CYC_WR16 = 3'd1,
        CYC_WR8  = 3'd2,
        CYC_BRST = 3'd3,
        CYC_RD8  = 3'd4
    } cyc_e;

endpackage

// File: rtl/iop_decode.sv
module iop_decode
    import iop_pkg::*;
#(
    parameter int NSLOTS = 4,
    parameter int MAXW   = 2,
    parameter logic [NSLOTS*PAGE_AW-1:0] SLOT_BASE  = '0,
    parameter logic [NSLOTS*WCNT_W-1:0]  SLOT_WORDS = '0,
    parameter logic [NSLOTS*FLAG_W-1:0]  SLOT_FLAGS = '0,
    localparam int SW  = (NSLOTS > 1) ? $clog2(NSLOTS) : 1,
    localparam int WIW = (MAXW > 1) ? $clog2(MAXW) : 1
) (
    input  logic [PAGE_AW-2:0] word_addr,
    output logic               hit,
    output logic [SW-1:0]      slot,
    output logic [WIW-1:0]     widx
);

    logic [NSLOTS-1:0]          match;
    logic [NSLOTS-1:0][WIW-1:0] offs;

    for (genvar i = 0; i < NSLOTS; i++) begin : g_slot
        localparam logic [PAGE_AW-1:0] BASE  = SLOT_BASE[i*PAGE_AW +: PAGE_AW];
        localparam int                 WORDS = int'(SLOT_WORDS[i*WCNT_W +: WCNT_W]);
        localparam logic [PAGE_AW-1:0] BW    = BASE >> 1;
        localparam logic [PAGE_AW-1:0] EW    = BW + PAGE_AW'(WORDS);

        if (BASE[0])
            $error("slot %0d base offset is odd", i);
        if (int'(BASE) + 2 * WORDS > (1 << PAGE_AW))
            $error("slot %0d extends beyond the I/O page", i);
        if (WORDS < 1 || WORDS > MAXW)
            $error("slot %0d word count out of range", i);

        logic [PAGE_AW-1:0] wa_ext;
        logic [PAGE_AW-1:0] rel;
        assign wa_ext   = {1'b0, word_addr};
        assign rel      = wa_ext - BW;
        assign match[i] = SLOT_FLAGS[i*FLAG_W + FB_PRESENT]
                          && (wa_ext >= BW) && (wa_ext < EW);
        assign offs[i]  = rel[WIW-1:0];
    end

    // lowest-numbered matching slot wins
    always_comb begin
        hit  = 1'b0;
        slot = '0;
        widx = '0;
        for (int i = NSLOTS - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit  = 1'b1;
                slot = SW'(i);
                widx = offs[i];
            end
        end
    end

endmodule

// File: rtl/iop_merge.sv
module iop_merge
    import iop_pkg::*;
(
    input  logic [DW-1:0] old_word,
    input  logic [7:0]    byte_val,
    input  logic          hi_lane,
    output logic [DW-1:0] merged
);

    always_comb begin
        merged = old_word;
        if (hi_lane) merged[15:8] = byte_val;
        else         merged[7:0]  = byte_val;
    end

endmodule

// File: rtl/iopage_responder.sv
module iopage_responder
    import iop_pkg::*;
#(
    parameter int NSLOTS = 4,
    parameter int MAXW   = 2,
    parameter logic [NSLOTS*PAGE_AW-1:0] SLOT_BASE =
        {13'h0400, 13'h0300, 13'h0200, 13'h0100},
    parameter logic [NSLOTS*WCNT_W-1:0] SLOT_WORDS =
        {4'd1, 4'd1, 4'd1, 4'd2},
    parameter logic [NSLOTS*FLAG_W-1:0] SLOT_FLAGS =
        {5'b10001, 5'b00011, 5'b00101, 5'b01001},
    parameter logic [NSLOTS*DW-1:0] SLOT_INIT =
        {16'h7777, 16'h0000, 16'hBEEF, 16'h1111}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic [2:0]          cyc,
    input  logic [PAGE_AW-1:0]  addr,
    input  logic [DW-1:0]       wdata,
    output logic                ack,
    output logic                err,
    output logic                err_tmo,
    output logic [DW-1:0]       rdata
);

    localparam int SW  = (NSLOTS > 1) ? $clog2(NSLOTS) : 1;
    localparam int WIW = (MAXW > 1) ? $clog2(MAXW) : 1;
    localparam int NW  = NSLOTS * MAXW;
    localparam int IW  = (NW > 1) ? $clog2(NW) : 1;
    localparam int MULW = IW + 1;

    typedef struct packed {
        logic                   ack;
        logic                   err;
        logic                   tmo;
        logic [DW-1:0]          rdata;
        logic [NW-1:0][DW-1:0]  regs;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        s = '0;
        for (int k = 0; k < NW; k++)
            s.regs[k] = SLOT_INIT[(k / MAXW)*DW +: DW];
        return s;
    endfunction

    localparam state_t ST_RST = reset_state();

    state_t q, d;

    // per-slot option vectors and per-word reset-clear mask
    logic [NSLOTS-1:0] f_dummy, f_rdonly, f_wronly;
    logic [NW-1:0]     clr_word;

    for (genvar i = 0; i < NSLOTS; i++) begin : g_flags
        localparam logic [FLAG_W-1:0] F = SLOT_FLAGS[i*FLAG_W +: FLAG_W];
        assign f_dummy[i]  = F[FB_DUMMY];
        assign f_rdonly[i] = F[FB_RDONLY];
        assign f_wronly[i] = F[FB_WRONLY];
        for (genvar w = 0; w < MAXW; w++) begin : g_word
            assign clr_word[i*MAXW + w] = F[FB_PRESENT] && F[FB_CLRRST] && !F[FB_DUMMY];
        end
    end

    logic           hit;
    logic [SW-1:0]  slot;
    logic [WIW-1:0] widx;

    iop_decode #(
        .NSLOTS     (NSLOTS),
        .MAXW       (MAXW),
        .SLOT_BASE  (SLOT_BASE),
        .SLOT_WORDS (SLOT_WORDS),
        .SLOT_FLAGS (SLOT_FLAGS)
    ) u_dec (
        .word_addr (addr[PAGE_AW-1:1]),
        .hit       (hit),
        .slot      (slot),
        .widx      (widx)
    );

    logic [MULW-1:0] idx_wide;
    logic [IW-1:0]   idx;
    logic [DW-1:0]   old_word;
    logic [DW-1:0]   merge_base;
    logic [DW-1:0]   merged;
    logic            s_dummy, s_rdonly, s_wronly;

    assign idx_wide = MULW'(slot) * MULW'(MAXW) + MULW'(widx);
    assign idx      = idx_wide[IW-1:0];
    assign old_word = (int'(idx_wide) < NW) ? q.regs[idx] : '0;
    assign s_dummy  = (int'(slot) < NSLOTS) ? f_dummy[slot]  : 1'b0;
    assign s_rdonly = (int'(slot) < NSLOTS) ? f_rdonly[slot] : 1'b0;
    assign s_wronly = (int'(slot) < NSLOTS) ? f_wronly[slot] : 1'b0;

    // a write-only word cannot be read, so the merge starts from zero
    assign merge_base = s_wronly ? '0 : old_word;

    iop_merge u_merge (
        .old_word (merge_base),
        .byte_val (wdata[7:0]),
        .hi_lane  (addr[0]),
        .merged   (merged)
    );

    always_comb begin
        d       = q;
        d.ack   = 1'b0;
        d.err   = 1'b0;
        d.tmo   = 1'b0;
        d.rdata = '0;
        if (req) begin
            case (cyc_e'(cyc))
                CYC_BRST: begin
                    d.ack = 1'b1;
                    for (int k = 0; k < NW; k++)
                        if (clr_word[k]) d.regs[k] = '0;
                end
                CYC_RD16: begin
                    if (!hit) begin
                        d.err = 1'b1;
                        d.tmo = 1'b1;
                    end else if (s_wronly) begin
                        d.err = 1'b1;
                    end else begin
                        d.ack   = 1'b1;
                        d.rdata = s_dummy ? '0 : old_word;
                    end
                end
                CYC_WR16, CYC_WR8: begin
                    if (!hit) begin
                        d.err = 1'b1;
                        d.tmo = 1'b1;
                    end else if (s_rdonly) begin
                        d.err = 1'b1;
                    end else begin
                        d.ack = 1'b1;
                        if (!s_dummy && int'(idx_wide) < NW)
                            d.regs[idx] = (cyc_e'(cyc) == CYC_WR8) ? merged : wdata;
                    end
                end
                default: d.err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= ST_RST;
        else        q <= d;
    end

    assign ack     = q.ack;
    assign err     = q.err;
    assign err_tmo = q.tmo;
    assign rdata   = q.rdata;

    logic [NW*DW-1:0] store_flat;
    assign store_flat = q.regs;

endmodule

// File: rtl/iop_checks.sv
module iop_checks
    import iop_pkg::*;
#(
    parameter int STW = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input logic [2:0]       cyc,
    input logic             ack,
    input logic             err,
    input logic             err_tmo,
    input logic [DW-1:0]    rdata,
    input logic [STW-1:0]   store
);

    a_r1_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (ack ^ err));

    a_r1_no_unrequested: assert property (@(posedge clk) disable iff (!rst_n)
        (ack || err) |-> $past(req));

    a_r1_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |-> (rdata == '0));

    a_r6_tmo_with_err: assert property (@(posedge clk) disable iff (!rst_n)
        err_tmo |-> err);

    a_r8_err_keeps_store: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (store == $past(store)));

    a_r11_bad_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (req && cyc >= 3'd4) |=> (err && !err_tmo));

endmodule

bind iopage_responder iop_checks #(.STW(NW*DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .cyc     (cyc),
    .ack     (ack),
    .err     (err),
    .err_tmo (err_tmo),
    .rdata   (rdata),
    .store   (store_flat)
);

// File: tb/iopage_responder_test.sv
module iopage_responder_test;
    import iop_pkg::*;

    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  cyc = '0;
    logic [12:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        ack, err, err_tmo;
    logic [15:0] rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    // five slots: multiword clear-on-reset, read-only, dummy, write-only, absent
    iopage_responder #(
        .NSLOTS     (5),
        .MAXW       (2),
        .SLOT_BASE  ({13'h0500, 13'h0400, 13'h0300, 13'h0200, 13'h0100}),
        .SLOT_WORDS ({4'd1, 4'd1, 4'd1, 4'd1, 4'd2}),
        .SLOT_FLAGS ({5'b00000, 5'b10001, 5'b00011, 5'b00101, 5'b01001}),
        .SLOT_INIT  ({16'h0000, 16'h7777, 16'h5555, 16'hBEEF, 16'h1111})
    ) uut (
        .clk, .rst_n, .req, .cyc, .addr, .wdata,
        .ack, .err, .err_tmo, .rdata
    );

    typedef struct packed {
        logic [3:0]  rq;     // requirement number for the report
        logic [2:0]  cyc;
        logic [12:0] addr;
        logic [15:0] wd;
        logic        e_err;
        logic        e_tmo;
        logic [15:0] e_rd;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VT [NV] = '{
        '{4'd12, 3'd0, 13'h0100, 16'h0000, 1'b0, 1'b0, 16'h1111}, // R12 init
        '{4'd10, 3'd0, 13'h0102, 16'h0000, 1'b0, 1'b0, 16'h1111}, // R10
        '{4'd3,  3'd1, 13'h0100, 16'hA5C3, 1'b0, 1'b0, 16'h0000}, // R3
        '{4'd2,  3'd0, 13'h0101, 16'h0000, 1'b0, 1'b0, 16'hA5C3}, // R2 odd offset
        '{4'd10, 3'd0, 13'h0102, 16'h0000, 1'b0, 1'b0, 16'h1111}, // R10 untouched
        '{4'd4,  3'd2, 13'h0101, 16'h0012, 1'b0, 1'b0, 16'h0000}, // R4 high lane
        '{4'd4,  3'd0, 13'h0100, 16'h0000, 1'b0, 1'b0, 16'h12C3}, // R4
        '{4'd4,  3'd2, 13'h0100, 16'hFF99, 1'b0, 1'b0, 16'h0000}, // R4 low lane
        '{4'd4,  3'd0, 13'h0100, 16'h0000, 1'b0, 1'b0, 16'h1299}, // R4
        '{4'd10, 3'd1, 13'h0103, 16'h4242, 1'b0, 1'b0, 16'h0000}, // R10 second word
        '{4'd10, 3'd0, 13'h0102, 16'h0000, 1'b0, 1'b0, 16'h4242}, // R10
        '{4'd10, 3'd0, 13'h0100, 16'h0000, 1'b0, 1'b0, 16'h1299}, // R10
        '{4'd12, 3'd0, 13'h0200, 16'h0000, 1'b0, 1'b0, 16'hBEEF}, // R12
        '{4'd8,  3'd1, 13'h0200, 16'h0000, 1'b1, 1'b0, 16'h0000}, // R8 word
        '{4'd8,  3'd2, 13'h0201, 16'h0000, 1'b1, 1'b0, 16'h0000}, // R8 byte
        '{4'd8,  3'd0, 13'h0200, 16'h0000, 1'b0, 1'b0, 16'hBEEF}, // R8 kept
        '{4'd7,  3'd0, 13'h0300, 16'h0000, 1'b0, 1'b0, 16'h0000}, // R7
        '{4'd7,  3'd1, 13'h0300, 16'h1234, 1'b0, 1'b0, 16'h0000}, // R7
        '{4'd7,  3'd2, 13'h0301, 16'h00AB, 1'b0, 1'b0, 16'h0000}, // R7
        '{4'd7,  3'd0, 13'h0300, 16'h0000, 1'b0, 1'b0, 16'h0000}, // R7
        '{4'd5,  3'd0, 13'h0400, 16'h0000, 1'b1, 1'b0, 16'h0000}, // R5 read refused
        '{4'd5,  3'd2, 13'h0401, 16'h00AB, 1'b0, 1'b0, 16'h0000}, // R5 byte write
        '{4'd5,  3'd1, 13'h0400, 16'h1234, 1'b0, 1'b0, 16'h0000}, // R5 word write
        '{4'd6,  3'd0, 13'h0500, 16'h0000, 1'b1, 1'b1, 16'h0000}, // R6 absent slot
        '{4'd6,  3'd1, 13'h0600, 16'h5A5A, 1'b1, 1'b1, 16'h0000}, // R6
        '{4'd6,  3'd2, 13'h1FFF, 16'h0001, 1'b1, 1'b1, 16'h0000}, // R6 page top
        '{4'd6,  3'd0, 13'h0104, 16'h0000, 1'b1, 1'b1, 16'h0000}, // R6 past slot end
        '{4'd6,  3'd1, 13'h00FE, 16'h0000, 1'b1, 1'b1, 16'h0000}, // R6 before slot
        '{4'd11, 3'd4, 13'h0100, 16'h0000, 1'b1, 1'b0, 16'h0000}, // R11 byte read
        '{4'd11, 3'd7, 13'h0100, 16'h0000, 1'b1, 1'b0, 16'h0000}, // R11 bad code
        '{4'd11, 3'd0, 13'h0100, 16'h0000, 1'b0, 1'b0, 16'h1299}, // R11 no change
        '{4'd9,  3'd3, 13'h1234, 16'h0000, 1'b0, 1'b0, 16'h0000}, // R9 reset cycle
        '{4'd9,  3'd0, 13'h0100, 16'h0000, 1'b0, 1'b0, 16'h0000}  // R9 cleared
    };

    task automatic check(input string tag, input logic e_ack, input logic e_err,
                         input logic e_tmo, input logic [15:0] e_rd);
        checks++;
        if (ack !== e_ack || err !== e_err || err_tmo !== e_tmo || rdata !== e_rd) begin
            failures++;
            $display("FAIL %s: got ack=%b err=%b tmo=%b rdata=%h expected ack=%b err=%b tmo=%b rdata=%h",
                     tag, ack, err, err_tmo, rdata, e_ack, e_err, e_tmo, e_rd);
        end
    endtask

    task automatic op(input logic [2:0] c, input logic [12:0] a, input logic [15:0] w);
        @(negedge clk);
        req = 1'b1; cyc = c; addr = a; wdata = w;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got no completion expected finish within 5000 cycles");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12 outputs in reset", 1'b0, 1'b0, 1'b0, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 1'b0, 1'b0, 1'b0, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            op(VT[i].cyc, VT[i].addr, VT[i].wd);
            check($sformatf("R%0d vector %0d", VT[i].rq, i), !VT[i].e_err,
                  VT[i].e_err, VT[i].e_tmo, VT[i].e_rd);
        end

        // R9: untouched slots keep their words across the reset cycle
        op(3'd0, 13'h0102, 16'h0); check("R9 second word cleared", 1'b1, 1'b0, 1'b0, 16'h0000);
        op(3'd0, 13'h0200, 16'h0); check("R9 read-only kept", 1'b1, 1'b0, 1'b0, 16'hBEEF);

        // R1: request held for two cycles gives two responses, then idle
        @(negedge clk);
        req = 1'b1; cyc = 3'd0; addr = 13'h0200; wdata = '0;
        @(negedge clk);
        check("R1 first of held pair", 1'b1, 1'b0, 1'b0, 16'hBEEF);
        cyc = 3'd0; addr = 13'h0500;
        @(negedge clk);
        req = 1'b0;
        check("R1 second of held pair", 1'b0, 1'b1, 1'b1, 16'h0000);
        @(negedge clk);
        check("R1 idle after pair", 1'b0, 1'b0, 1'b0, 16'h0000);

        // R12: reset pin reloads initial values
        op(3'd1, 13'h0102, 16'hCAFE); check("R3 write before reload", 1'b1, 1'b0, 1'b0, 16'h0000);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        op(3'd0, 13'h0102, 16'h0); check("R12 reload second word", 1'b1, 1'b0, 1'b0, 16'h1111);

        finish_run();
    end

endmodule